// File: doc/BRIEF.md
# Masked Vector Element Blend Unit

This block assembles a 512-bit vector by picking every element from one of two source vectors. A per-element mask bit makes the choice. The mask is not a write-enable: a set bit takes the element from the second source, and a clear bit takes it from the first source. In zeroing mode, a clear bit writes zero instead.

The element width (32 or 64 bits) and the active vector length (128, 256 or 512 bits) are chosen on every transfer. These two inputs set how many elements are active. Every bit above the active length is cleared. The second source can supply a single scalar to every lane instead of its own lanes. This happens only when that operand is marked as coming from memory. Elements are copied bit-exactly, with no floating-point interpretation.

One registered stage sits between input and output. A two-state controller drives the output strobe:
- `ST_IDLE` moves to `ST_VALID` on a cycle with `in_valid` high.
- `ST_VALID` stays in `ST_VALID` while `in_valid` stays high.
- Either state moves to `ST_IDLE` on a cycle with `in_valid` low.
- Reset forces `ST_IDLE`.

Top module: `vec_blend_unit`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the block goes to `ST_IDLE`. After that edge, `out_valid` is 0 and `result` is all zeros.
- R2: With `mask_en`=1 and `zero_mode`=0, each active element j takes the second source when `mask[j]`=1 and the first source when `mask[j]`=0.
- R3: With `mask_en`=1 and `zero_mode`=1, each active element whose mask bit is 0 is written as zero. An element whose mask bit is 1 still takes the second source.
- R4: With `mask_en`=0, every active element takes the second source, whatever `mask` and `zero_mode` hold.
- R5: With `bcast`=1 and `src2_mem`=1, every element that would take the second source takes instead the lowest element of `src2`. That is bits 31:0 when `elem64`=0 and bits 63:0 when `elem64`=1.
- R6: With `src2_mem`=0, `bcast` has no effect on the result.
- R7: The `vlen` code is 0 for 128 bits, 1 for 256 bits and 2 for 512 bits; code 3 acts as 512 bits. With `elem64`=1 the active element count is 2, 4 or 8. With `elem64`=0 it is 4, 8 or 16.
- R8: Every `result` bit from the active vector length up to bit 511 is 0.
- R9: Element j occupies bits starting at j times the element width and is controlled by `mask[j]`. Mask bits at or beyond the active element count have no effect.
- R10: Any bit pattern in an element, including all-ones and sign-only patterns, is copied unchanged.
- R11: Inputs are sampled at a clock edge with `in_valid` high, and the blended `result` appears with `out_valid`=1 after that edge. After an edge with `in_valid` low, `out_valid` is 0 and `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample the operands on this edge |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector, or scalar in bits 63:0 when broadcast |
| mask | input | 16 | Per-element source selector |
| mask_en | input | 1 | 1: use the mask; 0: all active elements take the second source |
| elem64 | input | 1 | Element width: 0 = 32 bits, 1 = 64 bits |
| vlen | input | 2 | Vector length code: 0 = 128, 1 = 256, 2 or 3 = 512 |
| zero_mode | input | 1 | Zero the elements whose mask bit is 0 |
| bcast | input | 1 | Request scalar broadcast of the second source |
| src2_mem | input | 1 | Second source is a memory operand |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Blended vector |

## Verification
The bench builds the block with its default parameters: a 512-bit vector, 32-bit slots and 128-bit length steps. These are the only values that produce all six width-and-length combinations and the full 16-bit mask. With them, the bench reaches the boundaries where the element count changes: the top mask bits that must be ignored at short lengths, the odd slot of 64-bit broadcast, and the cleared upper bits. Back-to-back transfers and gaps in `in_valid` exercise every transition of the two-state controller.

// File: rtl/blend_pkg.sv
package blend_pkg;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_RSV = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } blend_state_e;

    // Number of 128-bit length steps selected by a length code.
    function automatic int unsigned step_count(input logic [1:0] code);
        unique case (vlen_e'(code))
            VL_128:  return 1;
            VL_256:  return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/blend_slot_ctrl.sv
module blend_slot_ctrl
    import blend_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int STEP_SLOTS = 4
) (
    input  logic             elem64,
    input  logic [1:0]       vlen,
    input  logic [NSLOT-1:0] mask,
    input  logic             mask_en,
    input  logic             zero_mode,
    output logic [NSLOT-1:0] active,
    output logic [NSLOT-1:0] take2,
    output logic [NSLOT-1:0] keep1
);

    int unsigned live_slots;

    always_comb begin
        live_slots = step_count(vlen) * STEP_SLOTS;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic sel_bit;
        always_comb begin
            sel_bit  = elem64 ? mask[s/2] : mask[s];
            active[s] = (s < live_slots);
            take2[s]  = !mask_en || sel_bit;
            keep1[s]  = !take2[s] && !zero_mode;
        end
    end

endmodule

// File: rtl/blend_slot.sv
module blend_slot #(
    parameter int SLOT_W = 32
) (
    input  logic [SLOT_W-1:0] own1,
    input  logic [SLOT_W-1:0] own2,
    input  logic [SLOT_W-1:0] scalar2,
    input  logic              use_scalar,
    input  logic              active,
    input  logic              take2,
    input  logic              keep1,
    output logic [SLOT_W-1:0] dout
);

    always_comb begin
        if (!active)
            dout = '0;
        else if (take2)
            dout = use_scalar ? scalar2 : own2;
        else if (keep1)
            dout = own1;
        else
            dout = '0;
    end

endmodule

// File: rtl/vec_blend_unit.sv
module vec_blend_unit
    import blend_pkg::*;
#(
    parameter int VEC_W  = 512,
    parameter int SLOT_W = 32,
    parameter int STEP_W = 128,
    localparam int NSLOT      = VEC_W / SLOT_W,
    localparam int STEP_SLOTS = STEP_W / SLOT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src1,
    input  logic [VEC_W-1:0] src2,
    input  logic [NSLOT-1:0] mask,
    input  logic             mask_en,
    input  logic             elem64,
    input  logic [1:0]       vlen,
    input  logic             zero_mode,
    input  logic             bcast,
    input  logic             src2_mem,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);

    logic [NSLOT-1:0] slot_active;
    logic [NSLOT-1:0] slot_take2;
    logic [NSLOT-1:0] slot_keep1;
    logic [VEC_W-1:0] blended;
    logic             use_scalar;
    blend_state_e     state_q, state_d;

    assign use_scalar = bcast && src2_mem;

    blend_slot_ctrl #(
        .NSLOT      (NSLOT),
        .STEP_SLOTS (STEP_SLOTS)
    ) u_ctrl (
        .elem64    (elem64),
        .vlen      (vlen),
        .mask      (mask),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .active    (slot_active),
        .take2     (slot_take2),
        .keep1     (slot_keep1)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_lane
        localparam int PAIR = s % 2;
        logic [SLOT_W-1:0] scalar2;
        assign scalar2 = elem64 ? src2[PAIR*SLOT_W +: SLOT_W] : src2[0 +: SLOT_W];

        blend_slot #(.SLOT_W(SLOT_W)) u_slot (
            .own1       (src1[s*SLOT_W +: SLOT_W]),
            .own2       (src2[s*SLOT_W +: SLOT_W]),
            .scalar2    (scalar2),
            .use_scalar (use_scalar),
            .active     (slot_active[s]),
            .take2      (slot_take2[s]),
            .keep1      (slot_keep1[s]),
            .dout       (blended[s*SLOT_W +: SLOT_W])
        );
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (in_valid)
            result <= blended;
    end

    assign out_valid = (state_q == ST_VALID);

endmodule

// File: rtl/vec_blend_chk.sv
module vec_blend_chk #(
    parameter int VEC_W = 512,
    parameter int NSLOT = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [VEC_W-1:0] src2,
    input logic             mask_en,
    input logic [1:0]       vlen,
    input logic             bcast,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (out_valid == $past(in_valid)));

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen == 2'd0) |=> (result[VEC_W-1:128] == '0));

    // R4
    nomask_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mask_en && !bcast && vlen == 2'd2) |=> (result == $past(src2)));

endmodule

bind vec_blend_unit vec_blend_chk #(.VEC_W(VEC_W), .NSLOT(NSLOT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src2      (src2),
    .mask_en   (mask_en),
    .vlen      (vlen),
    .bcast     (bcast),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/vec_blend_unit_bench.sv
module vec_blend_unit_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] src1 = '0;
    logic [511:0] src2 = '0;
    logic [15:0]  mask = '0;
    logic         mask_en = 1'b0;
    logic         elem64 = 1'b0;
    logic [1:0]   vlen = 2'd0;
    logic         zero_mode = 1'b0;
    logic         bcast = 1'b0;
    logic         src2_mem = 1'b0;
    logic         out_valid;
    logic [511:0] result;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    logic         exp_valid = 1'b0;
    logic [511:0] exp_res = '0;

    always #5 clk = ~clk;

    vec_blend_unit u_vec_blend_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src1(src1), .src2(src2),
        .mask(mask), .mask_en(mask_en), .elem64(elem64), .vlen(vlen),
        .zero_mode(zero_mode), .bcast(bcast), .src2_mem(src2_mem),
        .out_valid(out_valid), .result(result)
    );

    // Behavioural model: loop over elements, then bits.
    function automatic logic [511:0] model(
        input logic [511:0] a, input logic [511:0] b, input logic [15:0] m,
        input logic men, input logic e64, input logic [1:0] vl,
        input logic z, input logic bc, input logic mem);
        logic [511:0] r = '0;
        int ew = e64 ? 64 : 32;
        int bits = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
        int n = bits / ew;
        for (int j = 0; j < n; j++) begin
            for (int k = 0; k < ew; k++) begin
                if (!men || m[j])
                    r[j*ew+k] = (bc && mem) ? b[k] : b[j*ew+k];
                else if (z)
                    r[j*ew+k] = 1'b0;
                else
                    r[j*ew+k] = a[j*ew+k];
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_res   <= '0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid)
                exp_res <= model(src1, src2, mask, mask_en, elem64, vlen,
                                 zero_mode, bcast, src2_mem);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            total++;
            if (out_valid !== exp_valid || result !== exp_res) begin
                bad++;
                $display("FAIL %s: valid=%0b exp=%0b result=%h exp=%h",
                         cur_req, out_valid, exp_valid, result, exp_res);
            end
        end
    end

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic send(input string req, input logic [511:0] a, input logic [511:0] b,
                        input logic [15:0] m, input logic men, input logic e64,
                        input logic [1:0] vl, input logic z, input logic bc, input logic mem);
        @(negedge clk);
        cur_req = req;
        in_valid = 1'b1; src1 = a; src2 = b; mask = m; mask_en = men;
        elem64 = e64; vlen = vl; zero_mode = z; bcast = bc; src2_mem = mem;
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        cur_req = req;
        in_valid = 1'b0;
        src1 = rnd512(); src2 = rnd512(); mask = 16'($urandom());
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || result !== '0) begin
            bad++;
            $display("FAIL R1: valid=%0b result=%h exp valid=0 result=0", out_valid, result);
        end
        // R2: mask selects per element, both widths
        send("R2", rnd512(), rnd512(), 16'hA5C3, 1, 0, 2, 0, 0, 0);
        send("R2", rnd512(), rnd512(), 16'h005A, 1, 1, 2, 0, 0, 0);
        // R3: zeroing
        send("R3", rnd512(), rnd512(), 16'h3C0F, 1, 0, 2, 1, 0, 0);
        send("R3", rnd512(), rnd512(), 16'h0096, 1, 1, 2, 1, 0, 0);
        // R4: no mask
        send("R4", rnd512(), rnd512(), 16'h0000, 0, 0, 2, 1, 0, 0);
        send("R4", rnd512(), rnd512(), 16'h1234, 0, 1, 1, 0, 0, 0);
        // R5: broadcast from memory
        send("R5", rnd512(), rnd512(), 16'hF0F0, 1, 0, 2, 0, 1, 1);
        send("R5", rnd512(), rnd512(), 16'h00C5, 1, 1, 2, 1, 1, 1);
        send("R5", rnd512(), rnd512(), 16'h0000, 0, 1, 2, 0, 1, 1);
        // R6: broadcast ignored on register operand
        send("R6", rnd512(), rnd512(), 16'hFFFF, 1, 0, 2, 0, 1, 0);
        send("R6", rnd512(), rnd512(), 16'h00FF, 0, 1, 2, 0, 1, 0);
        // R7 / R8: every width and length, including code 3
        for (int e = 0; e < 2; e++)
            for (int v = 0; v < 4; v++)
                send("R7_R8", rnd512(), rnd512(), 16'($urandom()), 1, e[0], v[1:0], 0, 0, 0);
        // R9: top mask bits ignored at short length
        send("R9", rnd512(), rnd512(), 16'hFFF0, 1, 0, 0, 0, 0, 0);
        send("R9", rnd512(), rnd512(), 16'hFFFC, 1, 1, 0, 1, 0, 0);
        send("R9", rnd512(), rnd512(), 16'hFF0F, 1, 1, 1, 0, 0, 0);
        // R10: bit-exact special patterns
        send("R10", {16{32'hFFFFFFFF}}, {8{64'h8000000000000000}}, 16'h5555, 1, 1, 2, 0, 0, 0);
        send("R10", {16{32'h7FC00001}}, {16{32'h80000000}}, 16'hAAAA, 1, 0, 2, 0, 0, 0);
        // R11: gaps, hold and back-to-back
        idle("R11");
        idle("R11");
        send("R11", rnd512(), rnd512(), 16'h0F0F, 1, 0, 1, 0, 0, 0);
        idle("R11");
        for (int i = 0; i < 40; i++)
            send("R11", rnd512(), rnd512(), 16'($urandom()), 1'($urandom()),
                 1'($urandom()), 2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
        idle("R11");
        idle("R11");
        @(negedge clk);
        finish_run();
    end

endmodule